// File: doc/BRIEF.md
# Maskable Clock-Fault Interrupt Controller

This block gathers four live fault conditions from a clock generator into one interrupt line. The four conditions are: loss of signal on the crystal input, loss of signal on the reference clock input, PLL loss of lock, and PLL calibration in progress. Software can mask each source. Each source also has a sticky status bit. Software reads that bit to find out which event raised the interrupt, and clears it by writing zero to it.

The interrupt line is not latched. It follows the live conditions after masking, so a processor should take it as an edge-triggered interrupt and then read the status register. The two loss-of-signal inputs pass through a digital qualifier. The qualifier needs a long run of consecutive high cycles before it declares loss, and a short run of low cycles before it withdraws it. During power-on reset and soft reset, the calibration flag is forced high and the lock-loss flag is forced low.

There is one register port with a 1-bit address. Address 0 selects the status register and address 1 selects the mask register. Reads are combinational and writes take effect at the clock edge.

Top module: `fault_irq_ctrl`

## Requirements
- R1: `irq` is active high. It equals the OR of the live conditions whose mask bit is 0. It is not latched, so it falls as soon as the last unmasked condition goes away.
- R2: The mask register is at address 1 and holds 5 bits. A mask bit of 1 blocks the source at the same bit position from reaching `irq`. Bit 4 is stored but gates nothing. Masking never stops a status bit from setting.
- R3: The status register is at address 0 and uses this bit map: bit 0 calibration, bit 1 lock loss, bit 2 crystal loss of signal, bit 3 clock-input loss of signal. Bit 4 reads 0. A bit sets at the clock edge that follows the rising edge of its condition.
- R4: A write to address 0 clears each status bit whose write-data bit is 0 and leaves the bits written as 1 untouched. If a set and a clear hit the same bit in the same cycle, the set wins.
- R5: A status bit stays set after its condition has gone away, until software clears it.
- R6: A loss-of-signal condition asserts only after its raw input has been high for `ASSERT_CYC` consecutive clock edges. A shorter pulse has no effect on `irq` or on status.
- R7: A qualified loss-of-signal condition clears only after its raw input has been low for `DEASSERT_CYC` consecutive clock edges.
- R8: While `por_n` is low or `soft_rst` is high, the calibration condition reads as high and the lock-loss condition reads as low, whatever the raw inputs are.
- R9: When either reset is released, status reads 5'h01 and mask reads 5'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| cal_raw | input | 1 | PLL calibration in progress |
| lol_raw | input | 1 | PLL loss of lock |
| los_xtal_raw | input | 1 | Unqualified loss of signal on the crystal input |
| los_clk_raw | input | 1 | Unqualified loss of signal on the clock input |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects mask |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt, active high |

## Verification
The hardest situations to reach from the ports are the exact edges of the loss-of-signal qualifier and the collision between a status set and a software clear. For the qualifier, the bench holds a raw input high for exactly one edge fewer than the limit and confirms that neither `irq` nor status moves. It then holds the input for the full run and samples `irq` on the edge where the qualified flag appears. It applies the same exact count on the release side. For the collision, the bench drives the zero-write and a rising calibration input in the same cycle. It then confirms that the status bit reads set.

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl #(
  parameter int ASSERT_CYC   = 130,
  parameter int DEASSERT_CYC = 10
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       soft_rst,
  input  logic       cal_raw,
  input  logic       lol_raw,
  input  logic       los_xtal_raw,
  input  logic       los_clk_raw,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [4:0] reg_wdata,
  output logic [4:0] reg_rdata,
  output logic       irq
);
  localparam int MAXC = (ASSERT_CYC > DEASSERT_CYC) ? ASSERT_CYC : DEASSERT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ALIM = CW'(ASSERT_CYC - 1);
  localparam logic [CW-1:0] DLIM = CW'(DEASSERT_CYC - 1);

  logic [1:0] los_raw, los_q;
  logic [3:0] cond, cond_q, status_q, keep;
  logic [4:0] mask_q;
  logic       in_rst;

  assign los_raw = {los_clk_raw, los_xtal_raw};
  assign in_rst  = ~por_n | soft_rst;

  for (genvar j = 0; j < 2; j++) begin : g_qual
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        los_q[j] <= 1'b0;
        cnt      <= '0;
      end else if (soft_rst || los_raw[j] == los_q[j]) begin
        if (soft_rst) los_q[j] <= 1'b0;
        cnt <= '0;
      end else if (cnt == (los_q[j] ? DLIM : ALIM)) begin
        los_q[j] <= ~los_q[j];
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign cond = {los_q[1], los_q[0], lol_raw & ~in_rst, cal_raw | in_rst};
  assign keep = (reg_wr && !reg_addr) ? reg_wdata[3:0] : 4'hF;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      status_q <= 4'b0001;
      cond_q   <= 4'b0001;
      mask_q   <= '0;
    end else if (soft_rst) begin
      status_q <= 4'b0001;
      cond_q   <= 4'b0001;
      mask_q   <= '0;
    end else begin
      status_q <= (status_q & keep) | (cond & ~cond_q);
      cond_q   <= cond;
      if (reg_wr && reg_addr) mask_q <= reg_wdata;
    end
  end

  assign reg_rdata = reg_addr ? mask_q : {1'b0, status_q};
  assign irq       = |(cond & ~mask_q[3:0]);
endmodule

// File: rtl/fault_irq_ctrl_chk.sv
module fault_irq_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       soft_rst,
  input logic       reg_wr,
  input logic       reg_addr,
  input logic [4:0] reg_wdata,
  input logic       irq,
  input logic [1:0] los_raw,
  input logic [1:0] los_q,
  input logic [3:0] cond,
  input logic [3:0] status_q,
  input logic [4:0] mask_q
);
  p_all_masked_r2: assert property (@(posedge clk) disable iff (!por_n)
    (&mask_q[3:0]) |-> !irq);

  p_cal_forced_r8: assert property (@(posedge clk) disable iff (!por_n)
    (soft_rst && !mask_q[0]) |-> irq);

  p_reset_values_r9: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> (status_q == 4'b0001 && mask_q == 5'h00));

  for (genvar i = 0; i < 4; i++) begin : g_stat
    p_sticky_r5: assert property (@(posedge clk) disable iff (!por_n)
      $fell(status_q[i]) |-> $past((reg_wr && !reg_addr && !reg_wdata[i]) || soft_rst));
    p_set_r3: assert property (@(posedge clk) disable iff (!por_n)
      ($rose(cond[i]) && !soft_rst) |=> status_q[i]);
  end

  for (genvar j = 0; j < 2; j++) begin : g_los
    p_los_rise_r6: assert property (@(posedge clk) disable iff (!por_n)
      $rose(los_q[j]) |-> $past(los_raw[j]));
    p_los_fall_r7: assert property (@(posedge clk) disable iff (!por_n)
      $fell(los_q[j]) |-> ($past(!los_raw[j]) || $past(soft_rst)));
  end
endmodule

bind fault_irq_ctrl fault_irq_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq), .los_raw(los_raw),
  .los_q(los_q), .cond(cond), .status_q(status_q), .mask_q(mask_q)
);

// File: tb/fault_irq_ctrl_bench.sv
module fault_irq_ctrl_bench;
  localparam int A = 12;
  localparam int D = 4;

  logic clk = 0, por_n = 0, soft_rst = 0, cal_raw = 0, lol_raw = 0;
  logic los_xtal_raw = 0, los_clk_raw = 0, reg_wr = 0, reg_addr = 0;
  logic [4:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_irq_ctrl #(.ASSERT_CYC(A), .DEASSERT_CYC(D)) u_fault_irq_ctrl (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .cal_raw(cal_raw),
    .lol_raw(lol_raw), .los_xtal_raw(los_xtal_raw), .los_clk_raw(los_clk_raw),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  // {mask[4:0], cal, lol, expected irq}
  localparam logic [7:0] VEC [8] = '{
    {5'h00, 1'b0, 1'b0, 1'b0}, {5'h00, 1'b1, 1'b0, 1'b1},
    {5'h00, 1'b0, 1'b1, 1'b1}, {5'h01, 1'b1, 1'b0, 1'b0},
    {5'h01, 1'b1, 1'b1, 1'b1}, {5'h02, 1'b0, 1'b1, 1'b0},
    {5'h03, 1'b1, 1'b1, 1'b0}, {5'h10, 1'b1, 1'b0, 1'b1}};

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [4:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic a, output logic [4:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [4:0] v;
    repeat (3) @(negedge clk);
    chk("R8 irq from forced calibration during power-on reset", {4'b0, irq}, 5'h1);
    por_n = 1; #1;
    rd(0, v); chk("R9 status after power-on reset", v, 5'h01);
    rd(1, v); chk("R9 mask after power-on reset", v, 5'h00);
    chk("R1 irq idle", {4'b0, irq}, 5'h0);
    @(negedge clk);
    wr(0, 5'h00);
    rd(0, v); chk("R4 status cleared by zero write", v, 5'h00);

    for (int k = 0; k < 8; k++) begin
      wr(1, VEC[k][7:3]);
      cal_raw = VEC[k][2]; lol_raw = VEC[k][1];
      #1;
      chk($sformatf("R1 R2 vector %0d irq", k), {4'b0, irq}, {4'b0, VEC[k][0]});
      @(negedge clk);
    end
    cal_raw = 0; lol_raw = 0;
    wr(1, 5'h00);
    wr(0, 5'h00);

    cal_raw = 1; #1;
    chk("R1 irq follows calibration", {4'b0, irq}, 5'h1);
    @(negedge clk); @(negedge clk);
    cal_raw = 0; #1;
    chk("R1 irq not latched", {4'b0, irq}, 5'h0);
    rd(0, v); chk("R5 calibration status sticky", v, 5'h01);
    @(negedge clk);

    wr(0, 5'h00); wr(1, 5'h02);
    lol_raw = 1; #1;
    chk("R2 masked lock loss no irq", {4'b0, irq}, 5'h0);
    @(negedge clk); lol_raw = 0; @(negedge clk);
    rd(0, v); chk("R2 masked source still sets status", v, 5'h02);
    wr(1, 5'h00);

    cal_raw = 1; @(negedge clk); @(negedge clk); cal_raw = 0;
    rd(0, v); chk("R3 lock loss and calibration status", v, 5'h03);
    @(negedge clk);
    wr(0, 5'h1D);
    rd(0, v); chk("R4 one-bits keep status", v, 5'h01);
    wr(0, 5'h00);
    reg_wr = 1; reg_addr = 0; reg_wdata = 5'h00; cal_raw = 1;
    @(negedge clk);
    reg_wr = 0;
    rd(0, v); chk("R4 set wins over clear", v, 5'h01);
    cal_raw = 0; @(negedge clk);
    wr(0, 5'h00);

    los_xtal_raw = 1;
    repeat (A - 1) @(negedge clk);
    chk("R6 crystal loss before limit", {4'b0, irq}, 5'h0);
    @(negedge clk);
    chk("R6 crystal loss at limit", {4'b0, irq}, 5'h1);
    @(negedge clk);
    rd(0, v); chk("R3 crystal loss status bit 2", v, 5'h04);
    los_xtal_raw = 0;
    repeat (D - 1) @(negedge clk);
    chk("R7 crystal loss held before release limit", {4'b0, irq}, 5'h1);
    @(negedge clk);
    chk("R7 crystal loss cleared at release limit", {4'b0, irq}, 5'h0);
    rd(0, v); chk("R5 crystal loss status sticky", v, 5'h04);
    wr(0, 5'h00);

    los_clk_raw = 1;
    repeat (A - 1) @(negedge clk);
    los_clk_raw = 0;
    repeat (A + 2) @(negedge clk);
    chk("R6 short clock loss pulse ignored irq", {4'b0, irq}, 5'h0);
    rd(0, v); chk("R6 short clock loss pulse ignored status", v, 5'h00);
    los_clk_raw = 1;
    repeat (A + 1) @(negedge clk);
    rd(0, v); chk("R3 clock loss status bit 3", v, 5'h08);
    chk("R1 clock loss irq", {4'b0, irq}, 5'h1);
    los_clk_raw = 0;
    repeat (D + 1) @(negedge clk);
    wr(0, 5'h00);

    wr(1, 5'h01);
    lol_raw = 1; #1;
    chk("R1 lock loss irq before soft reset", {4'b0, irq}, 5'h1);
    soft_rst = 1; #1;
    chk("R8 lock loss forced low during soft reset", {4'b0, irq}, 5'h0);
    @(negedge clk);
    chk("R8 calibration forced high during soft reset", {4'b0, irq}, 5'h1);
    soft_rst = 0; lol_raw = 0; #1;
    rd(0, v); chk("R9 status after soft reset", v, 5'h01);
    rd(1, v); chk("R9 mask after soft reset", v, 5'h00);
    chk("R1 irq idle after soft reset", {4'b0, irq}, 5'h0);
    @(negedge clk);
    finish_run();
  end
endmodule